// File: doc/BRIEF.md
# Self-Synchronizing Stream Descrambler with Lock Detection

This block sits on the receive side of a 125 Mbaud twisted-pair link that whitens its symbol stream with an additive keystream. Each clock carries a group of zero, one or two scrambled bits with a valid count. The block strips the keystream and returns the plain bits with the same count one cycle later. A locked flag reports whether the keystream is trusted.

Synchronization needs no alignment to code groups. While the flag is low, the keystream register takes each incoming bit in inverted form. An idle line carries plaintext ones, so the inverted ciphertext is the keystream itself. Once 29 descrambled ones arrive in a row, the block locks and lets the register run on its own recurrence. While locked, a fresh idle run must appear before an unlock timer runs out, or the block drops back to hunting. A test input shortens that timeout so simulations stay short. The receiver feeds a signal-status input: when it is low, the block is forced out of lock, but data keeps flowing downstream.

Top module: `stream_descrambler`

## Requirements
- R1: `plain_cnt_o` equals the `cipher_cnt_i` of the previous cycle. `plain_o[0]` carries the first bit of the group and `plain_o[1]` the second. Positions at or above the count read 0.
- R2: While locked, each output bit is the input bit XOR a keystream bit k = s[10] XOR s[8] taken from an 11-bit register s (x^11 + x^9 + 1). The register then shifts left by one, and k enters at bit 0.
- R3: While unlocked, the register shifts in the inverted input bit instead of k. After 11 bits of idle (all-ones plaintext) in the unlocked state, every further output bit is 1.
- R4: `locked_o` rises on the clock edge after the registered idle-run count holds 29. The count is updated bit by bit in group order.
- R5: Any descrambled 0 resets the idle-run count to 0, and later ones in the same group count again from 0. The count saturates at 29.
- R6: With `fast_tmo_i` low, lock drops on the edge that follows 45125 locked cycles since the last timer reload, unless a reload happens in that cycle. The timer reloads in every cycle in which the registered count holds 29.
- R7: With `fast_tmo_i` high, the same timeout is 625 cycles.
- R8: While `sig_ok_i` is low, the next `locked_o` is 0 and the idle-run count clears. Output bits and counts are still produced as in R1 to R3.
- R9: After reset, `locked_o`, `plain_o` and `plain_cnt_o` are 0 and the keystream register is all zeros.
- R10: When timer expiry and a full idle run fall in the same cycle, the reload wins and lock holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_ok_i | input | 1 | Receiver signal status; low forces unlock |
| fast_tmo_i | input | 1 | Selects the short unlock timeout |
| cipher_i | input | 2 | Scrambled bits, bit 0 first |
| cipher_cnt_i | input | 2 | Number of valid bits in cipher_i (0 to 2) |
| plain_o | output | 2 | Descrambled bits, bit 0 first |
| plain_cnt_o | output | 2 | Number of valid bits in plain_o |
| locked_o | output | 1 | Keystream locked |

## Verification
Two functions can meet in one cycle: the unlock timer reaching its terminal state, and the idle-run counter reaching saturation, which reloads that timer. The bench provokes this in test-timeout mode. After each fresh lock it sends a stretch of non-idle data whose length sweeps across the 625-cycle window, then returns to idle, so for one length the run completes exactly when the timer expires. A bit-level reference model written from R1 to R10 predicts every output cycle, and `locked_o` must stay high in that coincident cycle.

// File: rtl/descr_pkg.sv
package descr_pkg;
  typedef enum logic {
    LK_HUNT  = 1'b0,
    LK_TRACK = 1'b1
  } lock_st_e;
endpackage

// File: rtl/descr_keystream.sv
// Shared keystream / ciphertext-capture register, one shift per valid bit.
module descr_keystream #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned KS_W   = 11,
  parameter int unsigned KS_TAP = 9,
  parameter int unsigned CW     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             track_i,
  input  logic [LANES-1:0] cipher_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [LANES-1:0] plain_o
);
  logic [KS_W-1:0] ks_q;
  logic [KS_W-1:0] chain [LANES+1];

  assign chain[0] = ks_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic on, key;
    assign on         = cnt_i > CW'(i);
    assign key        = chain[i][KS_W-1] ^ chain[i][KS_TAP-1];
    assign plain_o[i] = on & (cipher_i[i] ^ key);
    // hunting: inverted ciphertext equals keystream on idle
    assign chain[i+1] = on ? {chain[i][KS_W-2:0], track_i ? key : ~cipher_i[i]}
                           : chain[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ks_q <= '0;
    else         ks_q <= chain[LANES];
  end
endmodule

// File: rtl/descr_idle_run.sv
module descr_idle_run #(
  parameter int unsigned LANES = 2,
  parameter int unsigned RUN   = 29,
  parameter int unsigned CW    = 2,
  localparam int unsigned IW   = $clog2(RUN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [LANES-1:0] bits_i,
  input  logic [CW-1:0]    cnt_i,
  output logic             sat_o
);
  logic [IW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    for (int i = 0; i < LANES; i++) begin
      if (cnt_i > CW'(i)) begin
        if (!bits_i[i])              run_d = '0;
        else if (run_d != IW'(RUN))  run_d = run_d + IW'(1);
      end
    end
    if (clear_i) run_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  // relock decision taken from the registered count only
  assign sat_o = (run_q == IW'(RUN));
endmodule

// File: rtl/descr_unlock_timer.sv
// Maximal-length LFSR used as a timeout counter; terminal found by AND reduction.
module descr_unlock_timer #(
  parameter int unsigned     TW       = 16,
  parameter logic [TW-1:0]   TAPS     = 16'hD008,
  parameter logic [TW-1:0]   SEED     = 16'h0001,
  parameter int unsigned     NORM_CYC = 45125,
  parameter int unsigned     FAST_CYC = 625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic step_i,
  input  logic fast_i,
  output logic expire_o
);
  typedef logic [TW-1:0][TW-1:0] mat_t;

  function automatic logic [TW-1:0] lfsr_step(input logic [TW-1:0] s);
    return {s[TW-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [TW-1:0] mat_apply(input mat_t m, input logic [TW-1:0] v);
    logic [TW-1:0] acc;
    acc = '0;
    for (int j = 0; j < TW; j++) if (v[j]) acc = acc ^ m[j];
    return acc;
  endfunction

  // State reached after n steps from SEED, by repeated squaring of the step map.
  function automatic logic [TW-1:0] state_after(input int unsigned n);
    mat_t          cols, sq;
    logic [TW-1:0] v;
    v = SEED;
    for (int j = 0; j < TW; j++) cols[j] = lfsr_step(TW'(1) << j);
    for (int k = 0; k < 32; k++) begin
      if (n[k]) v = mat_apply(cols, v);
      for (int j = 0; j < TW; j++) sq[j] = mat_apply(cols, cols[j]);
      cols = sq;
    end
    return v;
  endfunction

  localparam logic [TW-1:0] TERM_NORM = state_after(NORM_CYC);
  localparam logic [TW-1:0] TERM_FAST = state_after(FAST_CYC);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] term;

  assign term     = fast_i ? TERM_FAST : TERM_NORM;
  assign expire_o = &(tmr_q ~^ term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmr_q <= SEED;
    else if (reload_i) tmr_q <= SEED;
    else if (step_i)   tmr_q <= lfsr_step(tmr_q);
  end
endmodule

// File: rtl/stream_descrambler.sv
module stream_descrambler
  import descr_pkg::*;
#(
  parameter int unsigned LANES    = 2,
  parameter int unsigned KS_W     = 11,
  parameter int unsigned KS_TAP   = 9,
  parameter int unsigned IDLE_RUN = 29,
  parameter int unsigned TMR_W    = 16,
  parameter logic [TMR_W-1:0] TMR_TAPS = 16'hD008,
  parameter logic [TMR_W-1:0] TMR_SEED = 16'h0001,
  parameter int unsigned NORM_CYC = 45125,
  parameter int unsigned FAST_CYC = 625,
  localparam int unsigned CW      = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_ok_i,
  input  logic             fast_tmo_i,
  input  logic [LANES-1:0] cipher_i,
  input  logic [CW-1:0]    cipher_cnt_i,
  output logic [LANES-1:0] plain_o,
  output logic [CW-1:0]    plain_cnt_o,
  output logic             locked_o
);
  lock_st_e         st_q, st_d;
  logic [LANES-1:0] plain_d, plain_q;
  logic [CW-1:0]    cnt_q;
  logic             idle_sat, tmr_expire;

  descr_keystream #(
    .LANES(LANES), .KS_W(KS_W), .KS_TAP(KS_TAP), .CW(CW)
  ) u_ks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .track_i  (st_q == LK_TRACK),
    .cipher_i (cipher_i),
    .cnt_i    (cipher_cnt_i),
    .plain_o  (plain_d)
  );

  descr_idle_run #(
    .LANES(LANES), .RUN(IDLE_RUN), .CW(CW)
  ) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!sig_ok_i),
    .bits_i  (plain_d),
    .cnt_i   (cipher_cnt_i),
    .sat_o   (idle_sat)
  );

  descr_unlock_timer #(
    .TW(TMR_W), .TAPS(TMR_TAPS), .SEED(TMR_SEED),
    .NORM_CYC(NORM_CYC), .FAST_CYC(FAST_CYC)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (idle_sat),
    .step_i   (st_q == LK_TRACK),
    .fast_i   (fast_tmo_i),
    .expire_o (tmr_expire)
  );

  always_comb begin
    st_d = st_q;
    if (!sig_ok_i)                       st_d = LK_HUNT;
    else if (idle_sat)                   st_d = LK_TRACK;  // reload beats expiry
    else if (st_q == LK_TRACK && tmr_expire) st_d = LK_HUNT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LK_HUNT;
      plain_q <= '0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      plain_q <= plain_d;
      cnt_q   <= cipher_cnt_i;
    end
  end

  assign plain_o     = plain_q;
  assign plain_cnt_o = cnt_q;
  assign locked_o    = (st_q == LK_TRACK);
endmodule

// File: rtl/descr_checker.sv
module descr_checker #(
  parameter int unsigned LANES = 2,
  parameter int unsigned CW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sig_ok_i,
  input logic [CW-1:0]    cipher_cnt_i,
  input logic [LANES-1:0] plain_o,
  input logic [CW-1:0]    plain_cnt_o,
  input logic             locked_o,
  input logic             sat_i,
  input logic             expire_i
);
  p_cnt_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> plain_cnt_o == $past(cipher_cnt_i));

  p_empty_group_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_cnt_o == '0 |-> plain_o == '0);

  p_single_lane_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_cnt_o == CW'(1) |-> !plain_o[1]);

  p_lock_from_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(sat_i));

  p_expire_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && expire_i && !sat_i |=> !locked_o);

  p_hold_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !expire_i && sig_ok_i |=> locked_o);

  p_sig_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_ok_i |=> !locked_o);

  p_reload_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && sat_i && sig_ok_i |=> locked_o);
endmodule

bind stream_descrambler descr_checker #(.LANES(LANES), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sig_ok_i     (sig_ok_i),
  .cipher_cnt_i (cipher_cnt_i),
  .plain_o      (plain_o),
  .plain_cnt_o  (plain_cnt_o),
  .locked_o     (locked_o),
  .sat_i        (idle_sat),
  .expire_i     (tmr_expire)
);

// File: tb/stream_descrambler_test.sv
`timescale 1ns/1ps
module stream_descrambler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_ok = 1'b0;
  logic       fast = 1'b0;
  logic [1:0] cin = '0;
  logic [1:0] ccnt = '0;
  logic [1:0] pout, pcnt;
  logic       lk;

  always #4 clk = ~clk;

  stream_descrambler uut (
    .clk_i(clk), .rst_ni(rst_n), .sig_ok_i(sig_ok), .fast_tmo_i(fast),
    .cipher_i(cin), .cipher_cnt_i(ccnt),
    .plain_o(pout), .plain_cnt_o(pcnt), .locked_o(lk)
  );

  typedef struct {
    logic [1:0] p;
    logic [1:0] n;
    logic       l;
    string      ptag;
    string      ltag;
  } exp_t;
  exp_t q[$];

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R4";
  bit    sig_r = 1'b1, fast_r = 1'b0;

  // transmit scrambler and reference receiver state
  logic [10:0] tx = 11'h5A5;
  logic [10:0] m_s = '0;
  int          m_cnt = 0, m_tmr = 0;
  bit          m_lock = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [1:0] pl, input logic [1:0] n);
    logic [1:0] c, pe;
    logic       k;
    bit         sat, lock_n;
    int         lim;
    exp_t       e;
    @(negedge clk);
    c = '0; pe = '0;
    for (int i = 0; i < 2; i++) if (i < n) begin
      k = tx[10] ^ tx[8]; tx = {tx[9:0], k}; c[i] = pl[i] ^ k;
    end
    cin = c; ccnt = n; sig_ok = sig_r; fast = fast_r;
    lim = fast_r ? 625 : 45125;
    sat = (m_cnt == 29);
    if (!sig_r)      lock_n = 0;
    else if (sat)    lock_n = 1;
    else if (m_lock && m_tmr == lim) lock_n = 0;
    else             lock_n = m_lock;
    e.ptag = m_lock ? "R2" : "R3";
    if (sat) m_tmr = 0; else if (m_lock) m_tmr = m_tmr + 1;
    for (int i = 0; i < 2; i++) if (i < n) begin
      k = m_s[10] ^ m_s[8];
      pe[i] = c[i] ^ k;
      m_s = {m_s[9:0], m_lock ? k : ~c[i]};
      m_cnt = pe[i] ? ((m_cnt == 29) ? 29 : m_cnt + 1) : 0;
    end
    if (!sig_r) m_cnt = 0;
    m_lock = lock_n;
    e.p = pe; e.n = n; e.l = lock_n; e.ltag = tag;
    q.push_back(e);
  endtask

  function automatic logic [1:0] pat(input int i);
    return (i % 7 == 3) ? 2'd1 : ((i % 11 == 5) ? 2'd0 : 2'd2);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(pcnt == e.n, "R1", pcnt, e.n);
        chk(pout == e.p, e.ptag, pout, e.p);
        chk(lk == e.l, e.ltag, lk, e.l);
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  task automatic relock(input int idle_cyc);
    sig_r = 0; repeat (2) drive(2'b11, 2'd2);
    sig_r = 1; repeat (idle_cyc) drive(2'b11, 2'd2);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(lk == 0, "R9", lk, 0);
    chk(pcnt == 0, "R9", pcnt, 0);
    chk(pout == 0, "R9", pout, 0);

    tag = "R4";
    for (int i = 0; i < 40; i++) drive(2'b11, pat(i));
    tag = "R2";
    for (int i = 0; i < 150; i++) drive(2'($urandom), pat(i));
    tag = "R8";
    sig_r = 0;
    for (int i = 0; i < 6; i++) drive(2'($urandom), 2'd2);
    sig_r = 1;
    tag = "R5";
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 13; i++) drive(2'b11, 2'd2);
      drive(2'b10, 2'd2);
    end
    for (int i = 0; i < 20; i++) drive(2'b11, 2'd2);
    drive(2'b10, 2'd2); drive(2'b01, 2'd1);
    for (int i = 0; i < 20; i++) drive(2'b11, 2'd2);

    tag = "R7";
    fast_r = 1;
    relock(40);
    for (int i = 0; i < 700; i++) drive({1'($urandom), 1'b0}, 2'd2);

    tag = "R10";
    for (int kk = 590; kk <= 640; kk++) begin
      relock(30);
      for (int i = 0; i < kk; i++) drive({1'($urandom), 1'b0}, 2'd2);
      for (int i = 0; i < 20; i++) drive(2'b11, 2'd2);
    end

    tag = "R6";
    fast_r = 0;
    relock(40);
    for (int i = 0; i < 45200; i++) drive({1'($urandom), 1'b0}, 2'd2);
    for (int i = 0; i < 10; i++) drive(2'b11, 2'd2);

    @(posedge clk); @(posedge clk); #3;
    summary();
  end
endmodule